// File: doc/BRIEF.md
# Transmit Frame Queue with Start Gating

This block buffers outgoing Ethernet frames between a DMA engine that fills it and a MAC transmitter that empties it. Every byte carries first-byte and last-byte markers, so the queue always knows where each frame begins and ends. The main job of the block is to decide when the MAC may begin a new frame. In store-and-forward mode it waits until a whole frame is present. In cut-through mode it begins as soon as a programmable number of bytes is buffered.

The usable size is set in 256-byte units, and writes past that size are held off with a ready signal. A flush command empties the queue and then absorbs the remainder of any frame the writer is still sending. A 2-bit enable code switches the queue on or off. If the MAC pulls from an empty queue in the middle of a frame, a sticky underflow flag is raised and the tail of that frame is thrown away inside the block.

Top module: `tx_frame_queue`

## Requirements
- R1: After reset the queue is empty: `level` is 0, `rd_valid`, `frame_ready`, `underflow` and `flush_busy` are 0, and `wr_ready` is 1 when the enable code is 2.
- R2: Accepted bytes leave in write order, each with its own first/last markers. `level` equals the number of bytes held.
- R3: With size code `s`, the capacity is (s+1)*256 bytes (code 7 gives 2048). `wr_ready` is 0 while `level` has reached the capacity, and the writer is held off without losing data.
- R4: When `cfg_store_fwd` is 1, a new frame is offered (`rd_valid`) only while at least one complete frame, ending in a last-byte marker, is held. The threshold code then has no effect.
- R5: When `cfg_store_fwd` is 0, a new frame is offered once a complete frame is held or `level` reaches the threshold. Threshold codes 0..7 select 32, 64, 96, 128, 192, 256, 384 and 512 bytes. Once a frame has started, each held byte is offered.
- R6: In cut-through mode the threshold is limited to the capacity, so a frame longer than the queue still starts.
- R7: Only enable code 2 activates the queue. With any other code, `wr_ready` and `rd_valid` are 0 and the held bytes are kept.
- R8: A one-cycle `flush_req` empties the queue and clears `underflow`. From the next cycle `flush_busy` is 1, and it clears by itself.
- R9: If a frame is being written when the flush arrives, its remaining bytes are accepted and discarded up to and including its last byte. `flush_busy` falls one cycle after that last byte. Frames written afterwards are stored.
- R10: A read request made inside a frame while the queue is empty sets a sticky `underflow`. Bytes of that frame that arrive later are discarded inside the block, with `rd_valid` held at 0, up to its last byte.
- R11: `frame_ready` is 1 exactly when the queue is active, not flushing, not inside or discarding a frame, and the start condition of R4 or R5 holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 2 | Queue enable code, 2 = active |
| cfg_store_fwd | input | 1 | 1 = store-and-forward, 0 = cut-through |
| cfg_thresh | input | 3 | Cut-through start threshold code |
| cfg_size | input | 3 | Capacity in 256-byte units, minus one |
| flush_req | input | 1 | Flush command pulse |
| wr_valid | input | 1 | Writer presents a byte |
| wr_first | input | 1 | Byte is the first of a frame |
| wr_last | input | 1 | Byte is the last of a frame |
| wr_data | input | 8 | Byte value |
| wr_ready | output | 1 | Byte is accepted this cycle |
| rd_en | input | 1 | MAC takes the offered byte / requests a byte |
| rd_valid | output | 1 | A byte is offered |
| rd_first | output | 1 | Offered byte begins a frame |
| rd_last | output | 1 | Offered byte ends a frame |
| rd_data | output | 8 | Offered byte value |
| frame_ready | output | 1 | A new frame may begin |
| level | output | 12 | Bytes held |
| underflow | output | 1 | Sticky mid-frame underflow flag |
| flush_busy | output | 1 | Flush in progress |

## Verification
The hardest state to reach is a cut-through underflow followed by the internal discard of the frame's tail. The MAC must already be inside a frame, drain the queue completely, and then ask for another byte, while the writer still owes the rest of that frame. The stimulus uses the lowest threshold with an eager reader, then stalls the writer partway through a long frame for longer than the buffered bytes last. A second hard case is a flush that lands while a frame is half written. The writer keeps streaming through the flush, and the stimulus checks both that the tail is swallowed and that the next frame is stored normally.

// File: rtl/txq_pkg.sv
// Package: shared types and decode helpers for the transmit frame queue.
// Assumes byte-wide storage; each entry carries frame boundary markers.
package txq_pkg;

    localparam int BYTE_W = 8;

    // Enable code that activates the queue; every other code idles it.
    localparam logic [1:0] QEN_ACTIVE = 2'd2;

    // One stored byte with its frame markers.
    typedef struct packed {
        logic              first;
        logic              last;
        logic [BYTE_W-1:0] data;
    } txq_entry_t;

    // Cut-through start threshold in bytes for a 3-bit code.
    function automatic logic [9:0] thresh_bytes(input logic [2:0] code);
        logic [9:0] b;
        case (code)
            3'd0:    b = 10'd32;
            3'd1:    b = 10'd64;
            3'd2:    b = 10'd96;
            3'd3:    b = 10'd128;
            3'd4:    b = 10'd192;
            3'd5:    b = 10'd256;
            3'd6:    b = 10'd384;
            default: b = 10'd512;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/txq_store.sv
// Module: circular byte store for the transmit frame queue.
// Holds DEPTH entries with a write and a read pointer. The head entry is
// read combinationally. Assumes the caller never pushes when full or pops
// when empty; clear returns both pointers to zero and wins over push/pop.
module txq_store
    import txq_pkg::*;
#(
    parameter  int DEPTH = 2048,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
)(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       push,
    input  txq_entry_t push_ent,
    input  logic       pop,
    output txq_entry_t head_ent
);

    txq_entry_t       mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [PTR_W-1:0] wr_nxt;
    logic [PTR_W-1:0] rd_nxt;

    // Pointer advance: natural wrap for power-of-two depth, compare otherwise.
    generate
        if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
            assign wr_nxt = wr_ptr + PTR_W'(1);
            assign rd_nxt = rd_ptr + PTR_W'(1);
        end else begin : g_wrap
            assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
            assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
        end
    endgenerate

    // Storage write; the array needs no reset.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= push_ent;
        end
    end

    // Pointer update with clear taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) wr_ptr <= wr_nxt;
            if (pop)  rd_ptr <= rd_nxt;
        end
    end

    assign head_ent = mem[rd_ptr];

endmodule

// File: rtl/txq_occupancy.sv
// Module: byte and complete-frame accounting for the transmit frame queue.
// Tracks bytes held and frames whose last byte is held. Derives the
// capacity from the size code and the clamped cut-through threshold.
// Assumes push/pop are already qualified by the controllers.
module txq_occupancy
    import txq_pkg::*;
#(
    parameter  int UNIT_BYTES = 256,
    parameter  int MAX_UNITS  = 8,
    localparam int DEPTH      = UNIT_BYTES * MAX_UNITS,
    localparam int LVL_W      = $clog2(DEPTH + 1)
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             push,
    input  logic             push_last,
    input  logic             pop,
    input  logic             pop_last,
    input  logic [2:0]       size_code,
    input  logic [2:0]       thresh_code,
    output logic [LVL_W-1:0] level,
    output logic             have_frame,
    output logic             room,
    output logic             thresh_met
);

    logic [LVL_W-1:0] frames;
    logic [LVL_W-1:0] cap;
    logic [LVL_W-1:0] thr;
    logic [LVL_W-1:0] eff_thr;

    // Capacity in bytes, limited to the physical store.
    always_comb begin
        if (int'(size_code) + 1 >= MAX_UNITS) begin
            cap = LVL_W'(DEPTH);
        end else begin
            cap = LVL_W'((int'(size_code) + 1) * UNIT_BYTES);
        end
    end

    // Threshold never above capacity, so long frames can still start.
    always_comb begin
        thr     = LVL_W'(thresh_bytes(thresh_code));
        eff_thr = (thr > cap) ? cap : thr;
    end

    // Byte count update.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            level <= '0;
        end else if (push && !pop) begin
            level <= level + LVL_W'(1);
        end else if (pop && !push) begin
            level <= level - LVL_W'(1);
        end
    end

    // Complete-frame count update.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            frames <= '0;
        end else if ((push && push_last) && !(pop && pop_last)) begin
            frames <= frames + LVL_W'(1);
        end else if ((pop && pop_last) && !(push && push_last)) begin
            frames <= frames - LVL_W'(1);
        end
    end

    assign have_frame = (frames != '0);
    assign room       = (level < cap);
    assign thresh_met = (level >= eff_thr);

    // A stored byte never takes the queue past its configured capacity.
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !clear) |-> (level < cap));

    // Frames counted never exceed bytes held.
    assert_frames_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frames <= level);

endmodule

// File: rtl/txq_write_ctrl.sv
// Module: write-side acceptance and flush sequencing.
// Accepts bytes while active and below capacity. On a flush it raises
// flush_busy, swallows the tail of a frame in progress and then drops
// flush_busy by itself. Assumes first/last markers are well formed.
module txq_write_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic flush_req,
    input  logic q_active,
    input  logic room,
    input  logic wr_valid,
    input  logic wr_first,
    input  logic wr_last,
    output logic wr_ready,
    output logic store,
    output logic flush_busy
);

    logic mid_frame;
    logic fire;

    // During a flush only the tail of an open frame is taken.
    assign wr_ready = flush_busy ? mid_frame : (q_active && room);
    assign fire     = wr_valid && wr_ready;
    assign store    = fire && !flush_busy && !flush_req;

    // Track whether the writer is inside a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mid_frame <= 1'b0;
        end else if (fire) begin
            if (wr_last)       mid_frame <= 1'b0;
            else if (wr_first) mid_frame <= 1'b1;
        end
    end

    // Flush state: set by request, released once no frame is open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush_busy <= 1'b0;
        end else if (flush_req) begin
            flush_busy <= 1'b1;
        end else if (flush_busy && !mid_frame) begin
            flush_busy <= 1'b0;
        end
    end

    // Nothing is stored while a flush is in progress.
    assert_flush_discards_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_busy && wr_valid && wr_ready) |-> !store);

endmodule

// File: rtl/txq_read_ctrl.sv
// Module: frame start gating, read handshake and underflow handling.
// Offers a new frame under the store-and-forward or cut-through rule and
// then every held byte of it. A read from an empty queue inside a frame
// sets a sticky underflow and drains the frame's tail internally.
module txq_read_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic flush_req,
    input  logic flush_busy,
    input  logic q_active,
    input  logic store_fwd,
    input  logic have_data,
    input  logic have_frame,
    input  logic thresh_met,
    input  logic head_last,
    input  logic rd_en,
    output logic rd_valid,
    output logic frame_ready,
    output logic pop,
    output logic underflow
);

    logic in_frame;
    logic dropping;
    logic live;
    logic start_ok;
    logic take;
    logic drain;
    logic uf_event;

    // Start rule and read qualification.
    always_comb begin
        live        = q_active && !flush_busy;
        start_ok    = store_fwd ? have_frame : (have_frame || thresh_met);
        frame_ready = live && !dropping && !in_frame && start_ok;
        rd_valid    = live && !dropping && have_data && (in_frame || start_ok);
        take        = rd_en && rd_valid;
        drain       = live && dropping && have_data;
        uf_event    = rd_en && live && !dropping && in_frame && !have_data;
        pop         = take || drain;
    end

    // Frame position, discard state and sticky underflow.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_req) begin
            in_frame  <= 1'b0;
            dropping  <= 1'b0;
            underflow <= 1'b0;
        end else begin
            if (take) in_frame <= !head_last;
            if (drain && head_last) begin
                dropping <= 1'b0;
                in_frame <= 1'b0;
            end
            if (uf_event) begin
                underflow <= 1'b1;
                dropping  <= 1'b1;
            end
        end
    end

    // Underflow only rises on a read request.
    assert_underflow_on_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underflow) |-> $past(rd_en));

    // Underflow persists until a flush.
    assert_underflow_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && !flush_req) |=> underflow);

endmodule

// File: rtl/tx_frame_queue.sv
// Module: transmit frame queue top.
// Connects the byte store, occupancy accounting, write controller and read
// controller. Assumes one byte per cycle on each side and that the control
// fields are held steady by the surrounding register logic.
module tx_frame_queue
    import txq_pkg::*;
#(
    parameter  int UNIT_BYTES = 256,
    parameter  int MAX_UNITS  = 8,
    localparam int DEPTH      = UNIT_BYTES * MAX_UNITS,
    localparam int LVL_W      = $clog2(DEPTH + 1)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_enable,
    input  logic              cfg_store_fwd,
    input  logic [2:0]        cfg_thresh,
    input  logic [2:0]        cfg_size,
    input  logic              flush_req,
    input  logic              wr_valid,
    input  logic              wr_first,
    input  logic              wr_last,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              wr_ready,
    input  logic              rd_en,
    output logic              rd_valid,
    output logic              rd_first,
    output logic              rd_last,
    output logic [BYTE_W-1:0] rd_data,
    output logic              frame_ready,
    output logic [LVL_W-1:0]  level,
    output logic              underflow,
    output logic              flush_busy
);

    logic       q_active;
    logic       room;
    logic       thresh_met;
    logic       have_frame;
    logic       store;
    logic       pop;
    txq_entry_t push_ent;
    txq_entry_t head_ent;

    assign q_active = (cfg_enable == QEN_ACTIVE);
    assign push_ent = '{first: wr_first, last: wr_last, data: wr_data};

    txq_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (flush_req),
        .push     (store),
        .push_ent (push_ent),
        .pop      (pop),
        .head_ent (head_ent)
    );

    txq_occupancy #(.UNIT_BYTES(UNIT_BYTES), .MAX_UNITS(MAX_UNITS)) u_occ (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (flush_req),
        .push        (store),
        .push_last   (wr_last),
        .pop         (pop),
        .pop_last    (head_ent.last),
        .size_code   (cfg_size),
        .thresh_code (cfg_thresh),
        .level       (level),
        .have_frame  (have_frame),
        .room        (room),
        .thresh_met  (thresh_met)
    );

    txq_write_ctrl u_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_req  (flush_req),
        .q_active   (q_active),
        .room       (room),
        .wr_valid   (wr_valid),
        .wr_first   (wr_first),
        .wr_last    (wr_last),
        .wr_ready   (wr_ready),
        .store      (store),
        .flush_busy (flush_busy)
    );

    txq_read_ctrl u_rd (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_req   (flush_req),
        .flush_busy  (flush_busy),
        .q_active    (q_active),
        .store_fwd   (cfg_store_fwd),
        .have_data   (level != '0),
        .have_frame  (have_frame),
        .thresh_met  (thresh_met),
        .head_last   (head_ent.last),
        .rd_en       (rd_en),
        .rd_valid    (rd_valid),
        .frame_ready (frame_ready),
        .pop         (pop),
        .underflow   (underflow)
    );

    assign rd_first = head_ent.first;
    assign rd_last  = head_ent.last;
    assign rd_data  = head_ent.data;

    // Store-and-forward never opens a frame without a complete one held.
    assert_sf_whole_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_store_fwd && rd_valid && rd_first) |-> have_frame);

    // A flush leaves the queue empty, busy and with underflow cleared.
    assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |=> (level == '0 && flush_busy && !underflow));

    // An idle queue keeps its contents.
    assert_idle_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!q_active && !flush_busy && !flush_req) |=> (level == $past(level)));

    // Level stays within the physical store.
    assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));

endmodule

// File: tb/tx_frame_queue_test.sv
module tx_frame_queue_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_enable = 2'd2;
    logic        cfg_store_fwd = 1'b0;
    logic [2:0]  cfg_thresh = 3'd0;
    logic [2:0]  cfg_size = 3'd7;
    logic        flush_req = 1'b0;
    logic        wr_valid = 1'b0;
    logic        wr_first = 1'b0;
    logic        wr_last = 1'b0;
    logic [7:0]  wr_data = 8'd0;
    logic        wr_ready;
    logic        rd_en = 1'b0;
    logic        rd_valid;
    logic        rd_first;
    logic        rd_last;
    logic [7:0]  rd_data;
    logic        frame_ready;
    logic [11:0] level;
    logic        underflow;
    logic        flush_busy;

    tx_frame_queue uut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_store_fwd(cfg_store_fwd),
        .cfg_thresh(cfg_thresh), .cfg_size(cfg_size), .flush_req(flush_req),
        .wr_valid(wr_valid), .wr_first(wr_first), .wr_last(wr_last), .wr_data(wr_data),
        .wr_ready(wr_ready), .rd_en(rd_en), .rd_valid(rd_valid), .rd_first(rd_first),
        .rd_last(rd_last), .rd_data(rd_data), .frame_ready(frame_ready), .level(level),
        .underflow(underflow), .flush_busy(flush_busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    // Reference model state
    logic [9:0] m_q[$];
    int m_frames = 0;
    bit m_in = 0, m_drop = 0, m_uf = 0, m_fb = 0, m_wmid = 0;

    // Writer state
    int  w_q[$];
    int  w_len = 0, w_idx = 0;
    bit  w_act = 0;
    int  pause_at = -1, pause_left = 0;
    logic [7:0] wseq = 8'd0;
    bit  flush_pend = 0;

    task automatic check(string tag, string what, int act, int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic int thr_of(int c);
        case (c)
            0: return 32;  1: return 64;  2: return 96;  3: return 128;
            4: return 192; 5: return 256; 6: return 384; default: return 512;
        endcase
    endfunction

    // One clock: drive, compare against model, advance model and writer.
    task automatic tick();
        bit en, start_ok, e_wr_ready, e_rd_valid, e_fr, wacc, racc, drain, ufe, old_wmid;
        int cap, eff, lvl;
        logic [9:0] h;
        if (!w_act && w_q.size() > 0) begin
            w_len = w_q.pop_front(); w_idx = 0; w_act = 1;
        end
        flush_req = flush_pend; flush_pend = 0;
        if (w_act && !(w_idx == pause_at && pause_left > 0)) begin
            wr_valid = 1; wr_first = (w_idx == 0); wr_last = (w_idx == w_len - 1); wr_data = wseq;
        end else begin
            wr_valid = 0; wr_first = 0; wr_last = 0;
            if (w_act && pause_left > 0) pause_left--;
        end
        #1;
        e_wr_ready = 0;
        if (rst_n) begin
            en  = (cfg_enable == 2'd2);
            cap = (int'(cfg_size) + 1) * 256;
            eff = thr_of(int'(cfg_thresh));
            if (eff > cap) eff = cap;
            lvl = m_q.size();
            start_ok   = cfg_store_fwd ? (m_frames > 0) : (m_frames > 0 || lvl >= eff);
            e_wr_ready = m_fb ? m_wmid : (en && lvl < cap);
            e_rd_valid = en && !m_fb && !m_drop && lvl > 0 && (m_in || start_ok);
            e_fr       = en && !m_fb && !m_drop && !m_in && start_ok;
            check("R3", "wr_ready", wr_ready, e_wr_ready);
            check(cfg_store_fwd ? "R4" : "R5", "rd_valid", rd_valid, e_rd_valid);
            check("R11", "frame_ready", frame_ready, e_fr);
            check("R2", "level", level, lvl);
            check("R10", "underflow", underflow, m_uf);
            check("R8", "flush_busy", flush_busy, m_fb);
            if (e_rd_valid) check("R2", "rd_entry", {rd_first, rd_last, rd_data}, m_q[0]);
            wacc  = wr_valid && e_wr_ready;
            racc  = rd_en && e_rd_valid;
            drain = en && !m_fb && m_drop && lvl > 0;
            ufe   = rd_en && en && !m_fb && !m_drop && m_in && lvl == 0;
            old_wmid = m_wmid;
            if (wacc) m_wmid = wr_last ? 0 : (wr_first ? 1 : m_wmid);
            if (flush_req) begin
                m_q.delete(); m_frames = 0; m_in = 0; m_drop = 0; m_uf = 0; m_fb = 1;
            end else begin
                if (racc || drain) begin
                    h = m_q.pop_front();
                    if (h[8]) m_frames--;
                    if (racc) m_in = !h[8];
                    if (drain && h[8]) begin m_drop = 0; m_in = 0; end
                end
                if (wacc && !m_fb) begin
                    m_q.push_back({wr_first, wr_last, wr_data});
                    if (wr_last) m_frames++;
                end
                if (ufe) begin m_uf = 1; m_drop = 1; end
                if (m_fb && !old_wmid) m_fb = 0;
            end
        end
        if (wr_valid && e_wr_ready) begin
            wseq++; w_idx++;
            if (w_idx == w_len) begin w_act = 0; pause_at = -1; end
        end
        @(negedge clk);
    endtask

    function automatic bit idle();
        return !w_act && w_q.size() == 0 && m_q.size() == 0 && !m_in && !m_drop && !m_fb;
    endfunction

    task automatic run_idle(int limit);
        int n = 0;
        while (!idle() && n < limit) begin tick(); n++; end
        check("R2", "reached idle", int'(idle()), 1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        repeat (3) tick();
        rst_n = 1;
        #1;
        // R1: reset state
        check("R1", "level", level, 0);
        check("R1", "rd_valid", rd_valid, 0);
        check("R1", "frame_ready", frame_ready, 0);
        check("R1", "underflow", underflow, 0);
        check("R1", "flush_busy", flush_busy, 0);
        check("R1", "wr_ready", wr_ready, 1);

        // R4: store-and-forward with several frame lengths
        cfg_store_fwd = 1; cfg_thresh = 0; rd_en = 1;
        w_q.push_back(1); w_q.push_back(40); w_q.push_back(300); w_q.push_back(64);
        run_idle(2000);

        // R5: every threshold code in cut-through mode
        cfg_store_fwd = 0;
        for (int c = 0; c < 8; c++) begin
            cfg_thresh = 3'(c);
            w_q.push_back(600);
            run_idle(2000);
        end

        // R3: back-pressure at the smallest capacity
        cfg_size = 0; cfg_thresh = 0; rd_en = 0;
        w_q.push_back(400);
        repeat (300) tick();
        check("R3", "level at capacity", level, 256);
        check("R3", "wr_ready at capacity", wr_ready, 0);
        rd_en = 1;
        run_idle(2000);

        // R6: threshold above capacity still starts a long frame
        cfg_thresh = 7;
        w_q.push_back(400);
        run_idle(2000);
        check("R6", "level after long frame", level, 0);

        // R7: non-active enable codes freeze the queue
        cfg_size = 7; cfg_store_fwd = 1; rd_en = 0;
        w_q.push_back(50);
        repeat (60) tick();
        cfg_enable = 2'd0; rd_en = 1;
        w_q.push_back(20);
        repeat (10) tick();
        check("R7", "level frozen code0", level, 50);
        check("R7", "rd_valid code0", rd_valid, 0);
        cfg_enable = 2'd3;
        repeat (5) tick();
        check("R7", "wr_ready code3", wr_ready, 0);
        cfg_enable = 2'd1;
        repeat (5) tick();
        check("R7", "level frozen code1", level, 50);
        cfg_enable = 2'd2;
        run_idle(500);

        // R8: flush with whole frames held
        rd_en = 0;
        w_q.push_back(30); w_q.push_back(30);
        repeat (70) tick();
        check("R8", "level before flush", level, 60);
        flush_pend = 1;
        tick();
        check("R8", "level after flush", level, 0);
        check("R8", "flush_busy set", flush_busy, 1);
        tick();
        check("R8", "flush_busy self clear", flush_busy, 0);

        // R9: flush while a frame is being written
        cfg_store_fwd = 0; cfg_thresh = 7;
        w_q.push_back(100);
        repeat (30) tick();
        flush_pend = 1;
        tick();
        while (w_act) tick();
        check("R9", "busy through tail", flush_busy, 1);
        tick();
        check("R9", "busy released", flush_busy, 0);
        check("R9", "tail discarded", level, 0);
        w_q.push_back(20);
        repeat (25) tick();
        check("R9", "next frame stored", level, 20);
        rd_en = 1;
        run_idle(500);

        // R10: cut-through underflow and tail discard
        cfg_thresh = 0;
        w_q.push_back(80);
        pause_at = 40; pause_left = 50;
        run_idle(1000);
        check("R10", "underflow raised", underflow, 1);
        check("R10", "tail drained", level, 0);
        w_q.push_back(10);
        run_idle(500);
        check("R10", "underflow sticky", underflow, 1);
        flush_pend = 1;
        tick();
        check("R8", "flush clears underflow", underflow, 0);
        repeat (3) tick();

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule